// File: doc/BRIEF.md
# Atomic Set/Clear General-Purpose Output Port

This block provides two 8-bit general-purpose output ports, one for each channel of a two-channel serial controller. Software never changes an output bit by writing the port value itself. It writes a mask to a set command address or to a clear command address instead. Every 1 in the mask forces the matching stored bit to 1 or to 0, and every 0 in the mask leaves that bit alone. Because of this, firmware can change single pins without a read-modify-write sequence, and one piece of code cannot undo a change made by another.

Writes arrive on a small host bus with a 4-bit address. A separate channel-select input picks the channel that a write reaches. The stored bits drive active-low pins through one output register stage, so a stored 1 pulls its pin low. A read port returns the stored value of the currently selected channel.

Top module: `gpo_setclr_port`

## Requirements
- R1: While reset is asserted and after it is released, both stored port values are 0x00 and every output pin is 1 (high).
- R2: A write with wr_en=1 to address 0xE (set command) makes the selected channel's stored value equal to its old value OR wdata.
- R3: A write with wr_en=1 to address 0xF (clear command) makes the selected channel's stored value equal to its old value AND NOT wdata.
- R4: A bit that is 0 in the written mask keeps its old value in both the set and the clear command.
- R5: ch_sel=0 selects channel A and ch_sel=1 selects channel B. A set or clear write leaves the channel that is not selected unchanged.
- R6: A cycle with wr_en=0, or a write to any address other than 0xE or 0xF, leaves both stored values unchanged.
- R7: The stored value updates on the clock edge at which the write is sampled. The pins show the inverted stored value one clock edge later.
- R8: rd_data always equals the stored value of the channel that ch_sel currently selects.
- R9: Stored bit i drives pin i of the same channel, and a stored 1 drives that pin low (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host write strobe, sampled on the clock edge |
| addr | input | 4 | Host register address |
| ch_sel | input | 1 | Channel select: 0 selects A, 1 selects B |
| wdata | input | 8 | Host write data (the command mask) |
| rd_data | output | 8 | Stored port value of the selected channel |
| pin_a_n | output | 8 | Channel A output pins, active low |
| pin_b_n | output | 8 | Channel B output pins, active low |

## Verification
The bench builds the block with its default parameters: an 8-bit port and the two command codes at 0xE and 0xF of a 4-bit address space. With these values, random addresses hit the two command codes often and also reach all fourteen ignored addresses. Random masks cover every bit position on both channels. Directed cases cover the all-ones and all-zeros masks, a clear of bits that are already clear, and the one-edge lag between a stored value and its pins.

// File: rtl/gpo_setclr_port.sv
module gpo_setclr_port #(
  parameter int PORT_W = 8,
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] SET_ADDR = 4'hE,
  parameter logic [ADDR_W-1:0] CLR_ADDR = 4'hF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ch_sel,
  input  logic [PORT_W-1:0] wdata,
  output logic [PORT_W-1:0] rd_data,
  output logic [PORT_W-1:0] pin_a_n,
  output logic [PORT_W-1:0] pin_b_n
);
  localparam int NUM_CH = 2;

  logic [NUM_CH-1:0][PORT_W-1:0] port_q;
  logic [NUM_CH-1:0][PORT_W-1:0] pin_q;

  wire is_set = wr_en && (addr == SET_ADDR);
  wire is_clr = wr_en && (addr == CLR_ADDR);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    wire sel = (ch_sel == 1'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               port_q[c] <= '0;
      else if (sel && is_set)   port_q[c] <= port_q[c] | wdata;
      else if (sel && is_clr)   port_q[c] <= port_q[c] & ~wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_q[c] <= '1;
      else        pin_q[c] <= ~port_q[c];
    end
  end

  assign rd_data = port_q[ch_sel];
  assign pin_a_n = pin_q[0];
  assign pin_b_n = pin_q[1];
endmodule

// File: rtl/gpo_setclr_port_chk.sv
module gpo_setclr_port_chk #(
  parameter int PORT_W = 8,
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] SET_ADDR = 4'hE,
  parameter logic [ADDR_W-1:0] CLR_ADDR = 4'hF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              ch_sel,
  input logic [PORT_W-1:0] wdata,
  input logic [PORT_W-1:0] port_a,
  input logic [PORT_W-1:0] port_b,
  input logic [PORT_W-1:0] pin_a_n,
  input logic [PORT_W-1:0] pin_b_n
);
  wire cmd = wr_en && (addr == SET_ADDR || addr == CLR_ADDR);

  always_comb if (!rst_n) AST_RESET_STATE: assert (port_a == '0 && port_b == '0); // R1

  AST_SET_A: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == SET_ADDR && !ch_sel) |=> port_a == ($past(port_a) | $past(wdata))); // R2
  AST_CLR_B: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == CLR_ADDR && ch_sel) |=> port_b == ($past(port_b) & ~$past(wdata))); // R3
  AST_OTHER_CH_A: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd && ch_sel) |=> $stable(port_a)); // R5
  AST_OTHER_CH_B: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd && !ch_sel) |=> $stable(port_b)); // R5
  AST_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd |=> ($stable(port_a) && $stable(port_b))); // R6
  AST_PIN_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pin_a_n == ~$past(port_a) && pin_b_n == ~$past(port_b))); // R7
endmodule

bind gpo_setclr_port gpo_setclr_port_chk #(
  .PORT_W(PORT_W), .ADDR_W(ADDR_W), .SET_ADDR(SET_ADDR), .CLR_ADDR(CLR_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .ch_sel(ch_sel),
  .wdata(wdata), .port_a(port_q[0]), .port_b(port_q[1]),
  .pin_a_n(pin_a_n), .pin_b_n(pin_b_n)
);

// File: tb/gpo_setclr_port_tb.sv
module gpo_setclr_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic       ch_sel = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rd_data, pin_a_n, pin_b_n;

  int checks = 0;
  int failures = 0;
  logic [7:0] exp_port [2];
  bit done = 0;

  always #5 clk = ~clk;

  gpo_setclr_port u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .ch_sel(ch_sel),
    .wdata(wdata), .rd_data(rd_data), .pin_a_n(pin_a_n), .pin_b_n(pin_b_n)
  );

  function automatic logic [7:0] next_val(logic [7:0] old, logic we, logic [3:0] a, logic [7:0] d);
    if (!we) return old;
    if (a == 4'hE) return old | d;
    if (a == 4'hF) return old & ~d;
    return old;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_reads(string req);
    for (int c = 0; c < 2; c++) begin
      ch_sel = c[0];
      #1;
      check(req, rd_data, exp_port[c]);
    end
  endtask

  task automatic op(logic we, logic [3:0] a, logic c, logic [7:0] d, string req);
    logic [7:0] old_a, old_b;
    old_a = exp_port[0];
    old_b = exp_port[1];
    @(negedge clk);
    wr_en = we; addr = a; ch_sel = c; wdata = d;
    exp_port[c] = next_val(exp_port[c], we, a, d);
    @(negedge clk);
    wr_en = 1'b0;
    check({req, " R7 pins lag A"}, pin_a_n, ~old_a);
    check({req, " R7 pins lag B"}, pin_b_n, ~old_b);
    check_reads({req, " R8"});
    @(negedge clk);
    check({req, " R9 pins A"}, pin_a_n, ~exp_port[0]);
    check({req, " R9 pins B"}, pin_b_n, ~exp_port[1]);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
    end
  end

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    exp_port[0] = '0;
    exp_port[1] = '0;
    repeat (3) @(negedge clk);
    check("R1 reset rd", rd_data, 8'h00);
    check("R1 reset pins A", pin_a_n, 8'hFF);
    check("R1 reset pins B", pin_b_n, 8'hFF);
    rst_n = 1'b1;
    @(negedge clk);
    check_reads("R1 after release");
    check("R1 pins A after release", pin_a_n, 8'hFF);

    op(1, 4'hE, 0, 8'h01, "R2 R9 set bit0 A");
    op(1, 4'hE, 0, 8'h80, "R2 R4 set bit7 A");
    op(1, 4'hE, 1, 8'hFF, "R2 R5 set all B");
    op(1, 4'hF, 1, 8'h0F, "R3 R4 clear low B");
    op(1, 4'hF, 0, 8'h40, "R3 clear already clear A");
    op(1, 4'hE, 0, 8'h00, "R4 zero set mask");
    op(1, 4'hF, 1, 8'h00, "R4 zero clear mask");
    op(0, 4'hE, 1, 8'h00, "R6 no strobe set");
    op(0, 4'hF, 0, 8'hFF, "R6 no strobe clear");
    for (int a = 0; a < 14; a++) op(1, a[3:0], a[0], 8'hA5, "R6 other address");
    op(1, 4'hF, 0, 8'hFF, "R3 clear all A");

    for (int i = 0; i < 400; i++) begin
      logic [3:0] a;
      a = ($urandom % 4 != 0) ? (4'hE + 4'($urandom % 2)) : 4'($urandom);
      op(1'($urandom % 8 != 0), a, 1'($urandom), 8'($urandom), "R2 R3 R5 random");
    end
    finish_run();
  end
endmodule